// File: doc/BRIEF.md
# Gathering PCI-to-Memory Write Buffer

This block collects single-beat PCI writes headed for system memory into two line-sized buffers. Each line is 32 bytes, held as four 64-bit double words, and each double word has its own byte-enable mask. The first write to a line takes a free buffer and starts a snoop request toward the processor bus. Later writes to the same line are merged into that buffer, byte by byte, while the buffer is still open. A buffer stops taking merges when it is scheduled for flush. That happens on the first of two events: a write arrives for a different line, or the snoop for the buffer is answered.

A buffer is written to memory once two things are true: its PCI write has ended and its snoop has been answered clean. The PCI write ends with an end-of-write pulse or with a move to another line. The buffer then issues one memory write request for each double word that has at least one byte enabled, in ascending order, and frees itself on the final grant. When no buffer is free, the PCI side is held off with a not-ready indication, and no merge is accepted either. The write address is a double-word address; the byte lanes are given by the byte enables.

Top module: `pciWriteGather`

## Requirements
- R1: After reset, wrReady is 1 and both snoopReq and memReq are 0.
- R2: The first accepted write to a line while buffers are free captures it and raises snoopReq with snoopLine equal to the line address (wrDwAddr without its two low bits). snoopReq and snoopLine hold until snoopAck.
- R3: A write to the line of an open buffer merges into it without a new snoop. Enabled bytes replace stored bytes, and the double word's byte-enable mask becomes the OR of all masks written to it.
- R4: A write to a different line goes into the free buffer, issues its own snoop for that line, and ends the PCI write of the previous buffer.
- R5: Once a buffer's snoop is answered, a later write to the same line is not merged. It takes another buffer with a new snoop, and the two buffers are written to memory as separate requests.
- R6: While both buffers hold data, wrReady is 0 and no write is accepted, even a write to an open buffer's line.
- R7: A snoop response with snoopRetry=1 re-raises snoopReq for the same line. A buffer is never written to memory before a response with snoopRetry=0.
- R8: A buffer is written to memory only after its snoop is clean and its PCI write has ended (pciEnd pulse or a write to another line). It issues one request per double word with a nonzero mask, in ascending double-word order, with memDwAddr = {line, double-word index}, and memData valid on the enabled bytes.
- R9: memReq and memDwAddr hold until memGnt. A buffer becomes free on the grant of its last double word, and wrReady then returns to 1.
- R10: A buffer whose masks are all zero is freed after its clean snoop and end of write, and it issues no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A PCI write beat is offered |
| wrDwAddr | input | 29 | Double-word address of the beat |
| wrData | input | 64 | Write data |
| wrBe | input | 8 | Byte enables of the beat |
| wrReady | output | 1 | Beat is accepted on a clock edge with wrValid high |
| pciEnd | input | 1 | One-cycle pulse: the current PCI write has ended |
| snoopReq | output | 1 | Snoop request for snoopLine |
| snoopLine | output | 27 | Line address to snoop |
| snoopAck | input | 1 | Snoop request taken |
| snoopResp | input | 1 | Snoop response valid (one cycle) |
| snoopRetry | input | 1 | With snoopResp: the snoop must be repeated |
| memReq | output | 1 | Memory write request |
| memDwAddr | output | 29 | Double-word address of the memory write |
| memData | output | 64 | Memory write data |
| memBe | output | 8 | Memory write byte enables |
| memGnt | input | 1 | Memory write accepted |

## Verification
A buffer that is wrongly kept open shows at the memory port as one merged request where two separate requests were expected. A buffer that is wrongly closed shows as an extra snoopReq within a few cycles of the write. A wrong mask shows in memBe, or as a missing or extra double word, on the first request after the snoop is answered. A lost valid flag or a stuck one shows within two cycles of the last grant: wrReady takes the wrong value, or a write that should stall is accepted. A drain before a clean answer shows as a memory request while the snoop is still pending or being retried.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  // index field wide enough for up to 16 buffers or double words per line
  localparam int IDX_W = 4;
  typedef logic [IDX_W-1:0] idx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // write beat into buffer wrIdx, double word wrDw
    logic wrNew;  // the beat opens a fresh line: clear all masks first
    idx_t wrIdx;
    idx_t wrDw;
    logic clrEn;  // memory took double word selDw of buffer selIdx
    idx_t selIdx; // buffer and double word shown at the memory port
    idx_t selDw;
  } strobe_t;
endpackage

// File: rtl/pwg_datapath.sv
module pwg_datapath
  import pwg_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int NUM_DW  = 4,
  parameter int NUM_BUF = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             st,
  input  logic [DATA_W-1:0]                   wrData,
  input  logic [DATA_W/8-1:0]                 wrBe,
  output logic [NUM_BUF-1:0][NUM_DW-1:0]      dirty,
  output logic [DATA_W-1:0]                   memData,
  output logic [DATA_W/8-1:0]                 memBe
);
  localparam int BE_W = DATA_W / 8;

  logic [NUM_BUF-1:0][NUM_DW-1:0][DATA_W-1:0] dataAll;
  logic [NUM_BUF-1:0][NUM_DW-1:0][BE_W-1:0]   beAll;

  for (genvar gb = 0; gb < NUM_BUF; gb++) begin : gBuf
    for (genvar gd = 0; gd < NUM_DW; gd++) begin : gDw
      localparam idx_t BI = idx_t'(gb);
      localparam idx_t DI = idx_t'(gd);
      logic [DATA_W-1:0] dq;
      logic [BE_W-1:0]   bq;
      logic hitWr, hitNew, hitClr;

      assign hitWr  = st.wrEn && st.wrIdx == BI && st.wrDw == DI;
      assign hitNew = st.wrEn && st.wrNew && st.wrIdx == BI;
      assign hitClr = st.clrEn && st.selIdx == BI && st.selDw == DI;

      always_ff @(posedge clk) begin
        if (!rstN)       bq <= '0;
        else if (hitWr)  bq <= (st.wrNew ? '0 : bq) | wrBe;
        else if (hitNew) bq <= '0;
        else if (hitClr) bq <= '0;
      end

      always_ff @(posedge clk) begin
        if (hitWr) begin
          for (int k = 0; k < BE_W; k++)
            if (wrBe[k]) dq[8*k +: 8] <= wrData[8*k +: 8];
        end
      end

      assign dataAll[gb][gd] = dq;
      assign beAll[gb][gd]   = bq;
      assign dirty[gb][gd]   = |bq;
    end
  end

  always_comb begin
    memData = '0;
    memBe   = '0;
    for (int b = 0; b < NUM_BUF; b++)
      for (int d = 0; d < NUM_DW; d++)
        if (st.selIdx == idx_t'(b) && st.selDw == idx_t'(d)) begin
          memData = dataAll[b][d];
          memBe   = beAll[b][d];
        end
  end

  // R8: memory only ever takes a double word that carries enabled bytes
  p_grant_has_bytes_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.clrEn |-> memBe != '0);
endmodule

// File: rtl/pwg_control.sv
module pwg_control
  import pwg_pkg::*;
#(
  parameter int LINE_W  = 27,
  parameter int DWI_W   = 2,
  parameter int NUM_DW  = 4,
  parameter int NUM_BUF = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrValid,
  input  logic [LINE_W+DWI_W-1:0]        wrDwAddr,
  output logic                           wrReady,
  input  logic                           pciEnd,
  output logic                           snoopReq,
  output logic [LINE_W-1:0]              snoopLine,
  input  logic                           snoopAck,
  input  logic                           snoopResp,
  input  logic                           snoopRetry,
  output logic                           memReq,
  output logic [LINE_W+DWI_W-1:0]        memDwAddr,
  input  logic                           memGnt,
  input  logic [NUM_BUF-1:0][NUM_DW-1:0] dirty,
  output strobe_t                        st
);
  // per-buffer state
  logic [NUM_BUF-1:0] valid, open, needSnp, clean, ended, elig;
  logic [LINE_W-1:0]  line [NUM_BUF];
  // snoop port and drain engine
  logic snpOwn, snpWait, drnBusy;
  idx_t snpIdx, drnIdx;

  logic [LINE_W-1:0] lineIn, drnLine;
  logic [DWI_W-1:0]  dwIn, curDwN;
  logic [NUM_DW-1:0] curDirty;
  logic hit, full, accept, alloc, merge, lastDw;
  idx_t hitIdx, freeIdx, needSel, eligIdx, curDw;

  assign elig = valid & clean & ended;

  always_comb begin
    lineIn  = wrDwAddr[LINE_W+DWI_W-1:DWI_W];
    dwIn    = wrDwAddr[DWI_W-1:0];
    hit = 1'b0; hitIdx = '0; freeIdx = '0; needSel = '0; eligIdx = '0;
    snoopLine = '0; drnLine = '0; curDirty = '0;
    for (int b = NUM_BUF - 1; b >= 0; b--) begin
      if (valid[b] && open[b] && line[b] == lineIn) begin
        hit = 1'b1; hitIdx = idx_t'(b);
      end
      if (!valid[b])  freeIdx = idx_t'(b);
      if (needSnp[b]) needSel = idx_t'(b);
      if (elig[b])    eligIdx = idx_t'(b);
      if (snpIdx == idx_t'(b)) snoopLine = line[b];
      if (drnIdx == idx_t'(b)) begin
        drnLine = line[b]; curDirty = dirty[b];
      end
    end
    curDw = '0; curDwN = '0;
    for (int d = NUM_DW - 1; d >= 0; d--)
      if (curDirty[d]) begin curDw = idx_t'(d); curDwN = DWI_W'(d); end
  end

  assign full     = &valid;
  assign wrReady  = !full;
  assign accept   = wrValid && !full;
  assign alloc    = accept && !hit;
  assign merge    = accept && hit;
  assign snoopReq = snpOwn && !snpWait;
  assign memReq   = drnBusy && |curDirty;
  assign lastDw   = $countones(curDirty) == 1;
  assign memDwAddr = {drnLine, curDwN};

  always_comb begin
    st.wrEn   = accept;
    st.wrNew  = alloc;
    st.wrIdx  = alloc ? freeIdx : hitIdx;
    st.wrDw   = idx_t'(dwIn);
    st.clrEn  = memReq && memGnt;
    st.selIdx = drnIdx;
    st.selDw  = curDw;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid <= '0; open <= '0; needSnp <= '0; clean <= '0; ended <= '0;
      snpOwn <= 1'b0; snpWait <= 1'b0; snpIdx <= '0;
      drnBusy <= 1'b0; drnIdx <= '0;
      for (int b = 0; b < NUM_BUF; b++) line[b] <= '0;
    end else begin
      // write side: a new line closes every other buffer
      for (int b = 0; b < NUM_BUF; b++) begin
        if (alloc && freeIdx == idx_t'(b)) begin
          valid[b] <= 1'b1; open[b] <= 1'b1; needSnp[b] <= 1'b1;
          clean[b] <= 1'b0; ended[b] <= 1'b0; line[b] <= lineIn;
        end else if (alloc && valid[b]) begin
          open[b] <= 1'b0; ended[b] <= 1'b1;
        end else if (merge && hitIdx == idx_t'(b)) begin
          ended[b] <= 1'b0;
        end else if (pciEnd && valid[b]) begin
          ended[b] <= 1'b1;
        end
      end
      // snoop port: one request in flight, index locked while asked
      if (!snpOwn && |needSnp) begin
        snpOwn <= 1'b1; snpIdx <= needSel;
        for (int b = 0; b < NUM_BUF; b++)
          if (needSel == idx_t'(b)) needSnp[b] <= 1'b0;
      end else if (snoopReq && snoopAck) begin
        snpWait <= 1'b1;
      end else if (snpWait && snoopResp) begin
        snpOwn <= 1'b0; snpWait <= 1'b0;
        for (int b = 0; b < NUM_BUF; b++)
          if (snpIdx == idx_t'(b)) begin
            open[b] <= 1'b0;
            if (snoopRetry) needSnp[b] <= 1'b1;
            else            clean[b]   <= 1'b1;
          end
      end
      // drain engine
      if (!drnBusy) begin
        if (|elig) begin drnBusy <= 1'b1; drnIdx <= eligIdx; end
      end else if (!(|curDirty) || (memGnt && lastDw)) begin
        drnBusy <= 1'b0;
        for (int b = 0; b < NUM_BUF; b++)
          if (drnIdx == idx_t'(b)) valid[b] <= 1'b0;
      end
    end
  end

  // R2: a pending snoop request keeps its line until taken
  p_snoop_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    snoopReq && !snoopAck |=> snoopReq && $stable(snoopLine));

  // R9: a memory request keeps its address until granted
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memDwAddr));

  for (genvar gb = 0; gb < NUM_BUF; gb++) begin : gChk
    // R7: a buffer is only released after a clean snoop and end of write
    p_free_needs_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(valid[gb]) |-> $past(clean[gb] && ended[gb]));
  end
endmodule

// File: rtl/pciWriteGather.sv
module pciWriteGather
  import pwg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int NUM_DW  = 4,
  parameter int NUM_BUF = 2,
  localparam int BE_W   = DATA_W / 8,
  localparam int DWI_W  = $clog2(NUM_DW),
  localparam int DWA_W  = ADDR_W - $clog2(BE_W),
  localparam int LINE_W = DWA_W - DWI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DWA_W-1:0]  wrDwAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BE_W-1:0]   wrBe,
  output logic              wrReady,
  input  logic              pciEnd,
  output logic              snoopReq,
  output logic [LINE_W-1:0] snoopLine,
  input  logic              snoopAck,
  input  logic              snoopResp,
  input  logic              snoopRetry,
  output logic              memReq,
  output logic [DWA_W-1:0]  memDwAddr,
  output logic [DATA_W-1:0] memData,
  output logic [BE_W-1:0]   memBe,
  input  logic              memGnt
);
  strobe_t st;
  logic [NUM_BUF-1:0][NUM_DW-1:0] dirty;

  pwg_control #(.LINE_W(LINE_W), .DWI_W(DWI_W), .NUM_DW(NUM_DW), .NUM_BUF(NUM_BUF)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrDwAddr(wrDwAddr), .wrReady(wrReady),
    .pciEnd(pciEnd), .snoopReq(snoopReq), .snoopLine(snoopLine), .snoopAck(snoopAck),
    .snoopResp(snoopResp), .snoopRetry(snoopRetry), .memReq(memReq),
    .memDwAddr(memDwAddr), .memGnt(memGnt), .dirty(dirty), .st(st)
  );

  pwg_datapath #(.DATA_W(DATA_W), .NUM_DW(NUM_DW), .NUM_BUF(NUM_BUF)) i_data (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData), .wrBe(wrBe),
    .dirty(dirty), .memData(memData), .memBe(memBe)
  );
endmodule

// File: tb/test_pciWriteGather.sv
module test_pciWriteGather;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 0, pciEnd = 0, snoopAck = 0, snoopResp = 0, snoopRetry = 0, memGnt = 0;
  logic [28:0] wrDwAddr = '0;
  logic [63:0] wrData = '0;
  logic [7:0]  wrBe = '0;
  logic wrReady, snoopReq, memReq;
  logic [26:0] snoopLine;
  logic [28:0] memDwAddr;
  logic [63:0] memData;
  logic [7:0]  memBe;

  pciWriteGather i_pciWriteGather (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrDwAddr(wrDwAddr), .wrData(wrData),
    .wrBe(wrBe), .wrReady(wrReady), .pciEnd(pciEnd), .snoopReq(snoopReq),
    .snoopLine(snoopLine), .snoopAck(snoopAck), .snoopResp(snoopResp),
    .snoopRetry(snoopRetry), .memReq(memReq), .memDwAddr(memDwAddr),
    .memData(memData), .memBe(memBe), .memGnt(memGnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, logCnt = 0;
  bit gntEn = 1'b1;
  logic [31:0] logAddr [0:31];
  logic [63:0] logData [0:31];
  logic [7:0]  logBe   [0:31];

  // memory model: grant at once when enabled, log what is written
  always @(negedge clk) begin
    if (memReq && gntEn) begin
      if (logCnt < 32) begin
        logAddr[logCnt] = {memDwAddr, 3'b000};
        logData[logCnt] = memData;
        logBe[logCnt]   = memBe;
      end
      logCnt = logCnt + 1;
      memGnt = 1'b1;
    end else memGnt = 1'b0;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] maskBytes(input logic [63:0] d, input logic [7:0] be);
    for (int k = 0; k < 8; k++) if (!be[k]) d[8*k +: 8] = 8'h00;
    return d;
  endfunction

  task automatic checkLog(input int n, input logic [31:0] addr, input logic [63:0] data,
                          input logic [7:0] be, input string req);
    check(logAddr[n] == addr, req, 64'(logAddr[n]), 64'(addr));
    check(logBe[n] == be, req, 64'(logBe[n]), 64'(be));
    check(maskBytes(logData[n], be) == maskBytes(data, be), req,
          maskBytes(logData[n], be), maskBytes(data, be));
  endtask

  task automatic doWrite(input logic [31:0] addr, input logic [63:0] data, input logic [7:0] be);
    @(negedge clk);
    wrValid = 1'b1; wrDwAddr = addr[31:3]; wrData = data; wrBe = be;
    while (!wrReady) @(negedge clk);
    @(posedge clk); #1 wrValid = 1'b0;
  endtask

  task automatic answerSnoop(input logic [31:0] addr, input logic retry, input string req);
    @(negedge clk);
    while (!snoopReq) @(negedge clk);
    check(snoopLine == addr[31:5], req, 64'(snoopLine), 64'(addr[31:5]));
    snoopAck = 1'b1;
    @(posedge clk); #1 snoopAck = 1'b0;
    @(negedge clk); snoopResp = 1'b1; snoopRetry = retry;
    @(posedge clk); #1 snoopResp = 1'b0; snoopRetry = 1'b0;
  endtask

  task automatic pulseEnd();
    @(negedge clk); pciEnd = 1'b1;
    @(posedge clk); #1 pciEnd = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(wrReady == 1'b1, "R1 wrReady", 64'(wrReady), 64'd1);
    check(snoopReq == 1'b0, "R1 snoopReq", 64'(snoopReq), 64'd0);
    check(memReq == 1'b0, "R1 memReq", 64'(memReq), 64'd0);
  endtask

  task automatic testMerge();
    int base = logCnt;
    doWrite(32'h1000, 64'h1111_1111_1111_1111, 8'h0F);
    doWrite(32'h1000, 64'h2222_2222_2222_2222, 8'hF0);
    doWrite(32'h1010, 64'h3333_3333_3333_3333, 8'hFF);
    pulseEnd();
    waitCyc(5);
    check(logCnt == base, "R8 no drain before snoop", 64'(logCnt - base), 64'd0);
    answerSnoop(32'h1000, 1'b0, "R2 first line snoop");
    waitCyc(3);
    check(snoopReq == 1'b0, "R3 merges add no snoop", 64'(snoopReq), 64'd0);
    waitCyc(6);
    check(logCnt == base + 2, "R8 enabled dwords only", 64'(logCnt - base), 64'd2);
    checkLog(base, 32'h1000, 64'h2222_2222_1111_1111, 8'hFF, "R3 merged dword0");
    checkLog(base + 1, 32'h1010, 64'h3333_3333_3333_3333, 8'hFF, "R8 ascending dword2");
  endtask

  task automatic testRetry();
    int base = logCnt;
    doWrite(32'h2048, 64'h0000_0000_0000_00AB, 8'h01);
    answerSnoop(32'h2048, 1'b1, "R7 first ask");
    waitCyc(3);
    check(snoopReq == 1'b1, "R7 retry reissues", 64'(snoopReq), 64'd1);
    check(snoopLine == 27'h2048 >> 5, "R7 retry line", 64'(snoopLine), 64'(32'h2048 >> 5));
    pulseEnd();
    waitCyc(5);
    check(logCnt == base, "R7 no drain while retried", 64'(logCnt - base), 64'd0);
    answerSnoop(32'h2048, 1'b0, "R7 second ask");
    waitCyc(8);
    check(logCnt == base + 1, "R7 drain after clean", 64'(logCnt - base), 64'd1);
    checkLog(base, 32'h2048, 64'hAB, 8'h01, "R8 single byte");
  endtask

  task automatic testFull();
    int base = logCnt;
    gntEn = 1'b0;
    doWrite(32'h3000, 64'hC1C1_C1C1_C1C1_C1C1, 8'hFF);
    doWrite(32'h3020, 64'hD1D1_D1D1_D1D1_D1D1, 8'hFF);
    @(negedge clk);
    wrValid = 1'b1; wrDwAddr = 29'(32'h4000 >> 3); wrData = 64'hE1E1_E1E1_E1E1_E1E1; wrBe = 8'hFF;
    waitCyc(3);
    check(wrReady == 1'b0, "R6 stall when both hold data", 64'(wrReady), 64'd0);
    answerSnoop(32'h3000, 1'b0, "R2 line C");
    answerSnoop(32'h3020, 1'b0, "R4 other buffer snoops line D");
    waitCyc(4);
    check(wrReady == 1'b0, "R6 still full before grant", 64'(wrReady), 64'd0);
    check(logCnt == base, "R9 no write without grant", 64'(logCnt - base), 64'd0);
    gntEn = 1'b1;
    while (!wrReady) @(negedge clk);
    check(logCnt == base + 1, "R9 freed on last grant", 64'(logCnt - base), 64'd1);
    @(posedge clk); #1 wrValid = 1'b0;
    answerSnoop(32'h4000, 1'b0, "R4 line E");
    pulseEnd();
    waitCyc(10);
    check(logCnt == base + 3, "R4 three lines written", 64'(logCnt - base), 64'd3);
    checkLog(base, 32'h3000, 64'hC1C1_C1C1_C1C1_C1C1, 8'hFF, "R4 line C first");
    checkLog(base + 1, 32'h3020, 64'hD1D1_D1D1_D1D1_D1D1, 8'hFF, "R4 line D second");
    checkLog(base + 2, 32'h4000, 64'hE1E1_E1E1_E1E1_E1E1, 8'hFF, "R6 held write kept");
  endtask

  task automatic testClosed();
    int base = logCnt;
    doWrite(32'h5000, 64'h5555_5555_5555_5555, 8'h0F);
    answerSnoop(32'h5000, 1'b0, "R5 first snoop");
    doWrite(32'h5008, 64'h6666_6666_6666_6666, 8'h0F);
    waitCyc(6);
    check(logCnt == base + 1, "R5 closed buffer drains alone", 64'(logCnt - base), 64'd1);
    checkLog(base, 32'h5000, 64'h5555_5555_5555_5555, 8'h0F, "R5 first buffer unmerged");
    answerSnoop(32'h5000, 1'b0, "R5 new snoop same line");
    pulseEnd();
    waitCyc(8);
    check(logCnt == base + 2, "R5 second request", 64'(logCnt - base), 64'd2);
    checkLog(base + 1, 32'h5008, 64'h6666_6666_6666_6666, 8'h0F, "R5 second buffer");
  endtask

  task automatic testEmpty();
    int base = logCnt;
    doWrite(32'h6000, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    answerSnoop(32'h6000, 1'b0, "R10 snoop");
    pulseEnd();
    waitCyc(8);
    check(logCnt == base, "R10 no memory write", 64'(logCnt - base), 64'd0);
    doWrite(32'h7000, 64'h7777_7777_7777_7777, 8'hFF);
    waitCyc(2);
    check(wrReady == 1'b1, "R10 empty buffer freed", 64'(wrReady), 64'd1);
    answerSnoop(32'h7000, 1'b0, "R2 line H");
    pulseEnd();
    waitCyc(8);
    check(logCnt == base + 1, "R8 line H written", 64'(logCnt - base), 64'd1);
    checkLog(base, 32'h7000, 64'h7777_7777_7777_7777, 8'hFF, "R8 line H data");
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    testReset();
    testMerge();
    testRetry();
    testFull();
    testClosed();
    testEmpty();
    waitCyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule